// File: doc/BRIEF.md
# DMA Channel Request Handshake and Transfer Counter

This block is the per-channel sequencing core of a DMA controller. It is handed one linked-list item at a time: a transfer count, a flow-control mode, a memory-to-memory flag, a burst-length code and a flag that marks the item as the end of its chain. It watches the four request lines of the attached peripheral: burst, single, last-burst and last-single. For each request it serves, it issues one command to an abstract bus-master port, counts the acknowledged beats, and then pulses a request-clear so that the peripheral can withdraw its request.

Two flow-control modes decide when an item ends. Under controller flow control, the programmed count fixes the number of beats. A burst is cut short when fewer beats remain than the burst length. Either request line starts a transfer, and the two last-request lines have no effect. Under peripheral flow control, the count is not used. The item ends once a transfer that was flagged by a last-request line has completed. Memory-to-memory items need no request at all: commands run back to back, and no request-clear is produced.

Each item ends with a one-cycle terminal-count pulse. If the item closes its chain, the channel then drops its enable. Otherwise it raises a next-item request and waits for the next load strobe.

Top module: `dma_flowctl_engine`

## Requirements
- R1: Under controller flow control, the total of acknowledged beats for an item equals the loaded count. A count of zero ends the item with no command issued.
- R2: Every item, in every mode, ends with `tc_pulse` high for exactly one cycle.
- R3: Under controller flow control, `req_burst` or `req_single` starts a transfer. `req_last_burst` and `req_last_single` have no effect on the number of commands or beats.
- R4: Under peripheral flow control, the loaded count is ignored. The item ends after the command that was started by a request carrying its last-request line (`req_last_burst` with `req_burst`, `req_last_single` with `req_single`) has been fully acknowledged.
- R5: `burst_sel` maps to a burst length: 0 gives 1 beat, 1 gives 4, 2 gives 8 and 3 gives 16. A burst request issues a command of that length. A single request issues a 1-beat command. When both requests are high, the burst request wins.
- R6: `req_clr` is high for one cycle, in the cycle after the final `beat_ack` of a request-driven command. No new command is issued before that pulse.
- R7: A memory-to-memory item (`item_m2m`=1) uses controller flow control. It issues commands without any request line being high and never pulses `req_clr`.
- R8: Under controller flow control, `cmd_beats` is the smaller of the burst length and the remaining count.
- R9: After the terminal count of an item loaded with `item_chain_end`=1, `ch_enable` is low. Otherwise `next_req` and `ch_enable` are high until `item_load`.
- R10: After reset, `ch_enable`, `cmd_valid`, `req_clr`, `tc_pulse` and `next_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| item_load | input | 1 | Strobe that loads an item while the channel is idle or waiting for the next item |
| item_count | input | 12 | Transfer count in beats (used under controller flow control only) |
| item_periph_fc | input | 1 | 1 selects peripheral flow control, 0 selects controller flow control |
| item_m2m | input | 1 | Memory-to-memory item |
| item_chain_end | input | 1 | Next-item pointer is zero |
| burst_sel | input | 2 | Burst-length code |
| req_burst | input | 1 | Peripheral burst request |
| req_single | input | 1 | Peripheral single request |
| req_last_burst | input | 1 | Marks the burst request as the last one |
| req_last_single | input | 1 | Marks the single request as the last one |
| req_clr | output | 1 | Request-clear pulse |
| cmd_valid | output | 1 | Command to the bus-master port |
| cmd_beats | output | 5 | Beat count of the command |
| cmd_ready | input | 1 | Bus master accepts the command |
| beat_ack | input | 1 | One beat completed |
| tc_pulse | output | 1 | Terminal count of the current item |
| next_req | output | 1 | Request for the next item |
| ch_enable | output | 1 | Channel active |

## Verification
If the remaining count is wrong, the mistake shows within one command: `cmd_beats` is not the shortened length, or the sum of acknowledged beats differs from the loaded count when `tc_pulse` arrives. A stale or missed last-request flag makes a peripheral-flow item end one command early, or never end, and this is seen by the time the terminal count is expected. A wrong handshake state shows in the cycle right after the final beat: either `req_clr` is missing, or it pulses on a memory-to-memory item, or a second command appears before the clear.

// File: rtl/dma_fc_pkg.sv
package dma_fc_pkg;
  localparam int BEAT_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ARB, ST_CMD, ST_XFER, ST_CLR, ST_TC
  } fc_state_t;

  function automatic logic [BEAT_W-1:0] burst_len(input logic [1:0] sel);
    case (sel)
      2'd0:    burst_len = BEAT_W'(1);
      2'd1:    burst_len = BEAT_W'(4);
      2'd2:    burst_len = BEAT_W'(8);
      default: burst_len = BEAT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/dma_req_pick.sv
module dma_req_pick
  import dma_fc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0]  remain,
  input  logic              periph_fc,
  input  logic              m2m,
  input  logic [1:0]        sel,
  input  logic              rq_burst,
  input  logic              rq_single,
  input  logic              rq_last_burst,
  input  logic              rq_last_single,
  output logic              go,
  output logic [BEAT_W-1:0] beats,
  output logic              last_flag
);
  logic [BEAT_W-1:0] blen;
  logic [BEAT_W-1:0] clipped;

  always_comb begin
    blen    = burst_len(sel);
    clipped = (remain < CNT_W'(blen)) ? remain[BEAT_W-1:0] : blen;
    go        = 1'b0;
    beats     = blen;
    last_flag = 1'b0;
    if (m2m) begin
      go    = 1'b1;
      beats = clipped;
    end else if (rq_burst) begin
      go        = 1'b1;
      beats     = periph_fc ? blen : clipped;
      last_flag = periph_fc & rq_last_burst;
    end else if (rq_single) begin
      go        = 1'b1;
      beats     = BEAT_W'(1);
      last_flag = periph_fc & rq_last_single;
    end
  end
endmodule

// File: rtl/dma_item_counter.sv
module dma_item_counter
  import dma_fc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_item,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              start_cmd,
  input  logic [BEAT_W-1:0] cmd_len,
  input  logic              ack,
  input  logic              dec_en,
  output logic [CNT_W-1:0]  remain,
  output logic              last_beat
);
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              remain_en, beat_en;

  always_comb begin
    remain_en = load_item | (ack & last_beat & dec_en);
    remain_d  = load_item ? load_count : (remain_q - CNT_W'(cmd_len));
    beat_en   = start_cmd | ack;
    beat_d    = start_cmd ? cmd_len : (beat_q - BEAT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      beat_q   <= '0;
    end else begin
      if (remain_en) remain_q <= remain_d;
      if (beat_en)   beat_q   <= beat_d;
    end
  end

  assign remain    = remain_q;
  assign last_beat = (beat_q == BEAT_W'(1));
endmodule

// File: rtl/dma_flowctl_engine.sv
module dma_flowctl_engine
  import dma_fc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              item_load,
  input  logic [CNT_W-1:0]  item_count,
  input  logic              item_periph_fc,
  input  logic              item_m2m,
  input  logic              item_chain_end,
  input  logic [1:0]        burst_sel,
  input  logic              req_burst,
  input  logic              req_single,
  input  logic              req_last_burst,
  input  logic              req_last_single,
  output logic              req_clr,
  output logic              cmd_valid,
  output logic [BEAT_W-1:0] cmd_beats,
  input  logic              cmd_ready,
  input  logic              beat_ack,
  output logic              tc_pulse,
  output logic              next_req,
  output logic              ch_enable
);
  fc_state_t         state_q, state_d;
  logic              itm_periph, itm_m2m, itm_end;
  logic [1:0]        itm_sel;
  logic [BEAT_W-1:0] cur_beats;
  logic              cur_last;
  logic              take_item, pick_go, pick_last, arb_launch;
  logic [BEAT_W-1:0] pick_beats;
  logic [CNT_W-1:0]  remain;
  logic              last_beat, periph_eff, item_done;

  assign periph_eff = itm_periph & ~itm_m2m;
  assign take_item  = item_load & ((state_q == ST_IDLE) | (state_q == ST_WAIT));

  dma_req_pick #(.CNT_W(CNT_W)) pick_i (
    .remain(remain), .periph_fc(periph_eff), .m2m(itm_m2m), .sel(itm_sel),
    .rq_burst(req_burst), .rq_single(req_single),
    .rq_last_burst(req_last_burst), .rq_last_single(req_last_single),
    .go(pick_go), .beats(pick_beats), .last_flag(pick_last)
  );

  dma_item_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n),
    .load_item(take_item), .load_count(item_count),
    .start_cmd((state_q == ST_CMD) & cmd_ready), .cmd_len(cur_beats),
    .ack((state_q == ST_XFER) & beat_ack), .dec_en(~periph_eff),
    .remain(remain), .last_beat(last_beat)
  );

  assign item_done  = periph_eff ? cur_last : (remain == '0);
  assign arb_launch = (state_q == ST_ARB) & (periph_eff | (remain != '0)) & pick_go;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_WAIT: if (item_load) state_d = ST_ARB;
      ST_ARB: begin
        if (!periph_eff && remain == '0) state_d = ST_TC;
        else if (pick_go)                state_d = ST_CMD;
      end
      ST_CMD:  if (cmd_ready) state_d = ST_XFER;
      ST_XFER: if (beat_ack && last_beat) state_d = ST_CLR;
      ST_CLR:  state_d = item_done ? ST_TC : ST_ARB;
      ST_TC:   state_d = itm_end ? ST_IDLE : ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      itm_periph <= 1'b0;
      itm_m2m    <= 1'b0;
      itm_end    <= 1'b1;
      itm_sel    <= '0;
      cur_beats  <= '0;
      cur_last   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_item) begin
        itm_periph <= item_periph_fc;
        itm_m2m    <= item_m2m;
        itm_end    <= item_chain_end;
        itm_sel    <= burst_sel;
      end
      if (arb_launch) begin
        cur_beats <= pick_beats;
        cur_last  <= pick_last;
      end
    end
  end

  assign cmd_valid = (state_q == ST_CMD);
  assign cmd_beats = cur_beats;
  assign req_clr   = (state_q == ST_CLR) & ~itm_m2m;
  assign tc_pulse  = (state_q == ST_TC);
  assign next_req  = (state_q == ST_WAIT);
  assign ch_enable = (state_q != ST_IDLE);
endmodule

// File: rtl/dma_flowctl_chk.sv
module dma_flowctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_clr,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [4:0] cmd_beats,
  input logic       tc_pulse,
  input logic       next_req,
  input logic       ch_enable,
  input logic       itm_m2m
);
  assert_tc_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);

  assert_clr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr |=> !req_clr && !cmd_valid);

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_beats));

  assert_beats_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_beats != 5'd0) && (cmd_beats <= 5'd16));

  assert_no_clr_m2m_R7: assert property (@(posedge clk) disable iff (!rst_n)
    itm_m2m |-> !req_clr);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_enable |-> !cmd_valid && !next_req && !tc_pulse && !req_clr);
endmodule

bind dma_flowctl_engine dma_flowctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_clr(req_clr), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_beats(cmd_beats), .tc_pulse(tc_pulse),
  .next_req(next_req), .ch_enable(ch_enable), .itm_m2m(itm_m2m)
);

// File: tb/dma_flowctl_engine_tb.sv
module dma_flowctl_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       periph;
    logic       m2m;
    logic [1:0] kind;      // 0 burst, 1 single, 2 both
    logic [1:0] sel;
    logic [11:0] size;
    logic [3:0] nreq;
    logic [7:0] exp_beats;
    logic [3:0] exp_cmds;
    logic [4:0] exp_first;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, 2'd1, 12'd10, 4'd0, 8'd10, 4'd3, 5'd4},   // R1 R8
    '{1'b0, 1'b0, 2'd1, 2'd1, 12'd3,  4'd0, 8'd3,  4'd3, 5'd1},   // R3 R5
    '{1'b0, 1'b0, 2'd0, 2'd3, 12'd16, 4'd0, 8'd16, 4'd1, 5'd16},  // R5
    '{1'b0, 1'b0, 2'd0, 2'd0, 12'd2,  4'd0, 8'd2,  4'd2, 5'd1},   // R5
    '{1'b1, 1'b0, 2'd0, 2'd2, 12'd5,  4'd3, 8'd24, 4'd3, 5'd8},   // R4
    '{1'b1, 1'b0, 2'd1, 2'd3, 12'd0,  4'd4, 8'd4,  4'd4, 5'd1},   // R4
    '{1'b0, 1'b1, 2'd0, 2'd2, 12'd20, 4'd0, 8'd20, 4'd3, 5'd8},   // R7
    '{1'b0, 1'b0, 2'd0, 2'd2, 12'd0,  4'd0, 8'd0,  4'd0, 5'd0},   // R1 zero
    '{1'b0, 1'b0, 2'd2, 2'd2, 12'd8,  4'd0, 8'd8,  4'd1, 5'd8},   // R5 priority
    '{1'b0, 1'b0, 2'd0, 2'd3, 12'd5,  4'd0, 8'd5,  4'd1, 5'd5},   // R8 clipped
    '{1'b1, 1'b0, 2'd2, 2'd1, 12'd9,  4'd2, 8'd8,  4'd2, 5'd4}    // R4 R5
  };

  logic        clk, rst_n;
  logic        item_load, item_periph_fc, item_m2m, item_chain_end;
  logic [11:0] item_count;
  logic [1:0]  burst_sel;
  logic        req_burst, req_single, req_last_burst, req_last_single;
  logic        req_clr, cmd_valid, cmd_ready, beat_ack, tc_pulse, next_req, ch_enable;
  logic [4:0]  cmd_beats;

  int n_checks, n_fail;

  dma_flowctl_engine #(.CNT_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .item_load(item_load), .item_count(item_count),
    .item_periph_fc(item_periph_fc), .item_m2m(item_m2m),
    .item_chain_end(item_chain_end), .burst_sel(burst_sel),
    .req_burst(req_burst), .req_single(req_single),
    .req_last_burst(req_last_burst), .req_last_single(req_last_single),
    .req_clr(req_clr), .cmd_valid(cmd_valid), .cmd_beats(cmd_beats),
    .cmd_ready(cmd_ready), .beat_ack(beat_ack), .tc_pulse(tc_pulse),
    .next_req(next_req), .ch_enable(ch_enable)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_item(input vec_t v, input bit chain_end, input string tag);
    int pending = 0, beats = 0, cmds = 0, first = 0, clr_bad = 0, left;
    bit req_up = 0, exp_clr = 0, done = 0;
    left = v.nreq;
    @(negedge clk);
    item_load = 1'b1; item_count = v.size; item_periph_fc = v.periph;
    item_m2m = v.m2m; item_chain_end = chain_end; burst_sel = v.sel;
    for (int cyc = 0; cyc < 600 && !done; cyc++) begin
      @(negedge clk);
      item_load = 1'b0;
      if (tc_pulse) begin
        done = 1;
      end else begin
        if (exp_clr && (req_clr !== !v.m2m)) clr_bad++;
        exp_clr = 0;
        if (req_clr) begin
          req_up = 0;
          {req_burst, req_single, req_last_burst, req_last_single} = 4'b0;
        end
        if (pending > 0) begin
          beat_ack = 1'b1; pending--; beats++;
          if (pending == 0) exp_clr = 1;
        end else beat_ack = 1'b0;
        if (cmd_valid) begin
          if (cmds == 0) first = cmd_beats;
          cmds++; pending = cmd_beats;
        end
        if (!v.m2m && !req_up && (!v.periph || left > 0)) begin
          req_up = 1;
          left--;
          req_burst  = (v.kind != 2'd1);
          req_single = (v.kind != 2'd0);
          // controller mode: last lines held high, must be ignored (R3)
          req_last_burst  = v.periph ? (req_burst  && left == 0) : 1'b1;
          req_last_single = v.periph ? (req_single && left == 0) : 1'b1;
        end
      end
    end
    beat_ack = 1'b0;
    {req_burst, req_single, req_last_burst, req_last_single} = 4'b0;
    check(done, {tag, " R2 terminal count seen"}, done, 1);
    check(beats == v.exp_beats, {tag, " R1/R4 beats"}, beats, v.exp_beats);
    check(cmds == v.exp_cmds, {tag, " R3/R4 commands"}, cmds, v.exp_cmds);
    check(first == v.exp_first, {tag, " R5/R8 first cmd_beats"}, first, v.exp_first);
    check(clr_bad == 0, {tag, " R6/R7 req_clr timing"}, clr_bad, 0);
    @(negedge clk);
    check(tc_pulse == 1'b0, {tag, " R2 tc one cycle"}, tc_pulse, 0);
    if (chain_end)
      check(ch_enable == 1'b0, {tag, " R9 enable dropped"}, ch_enable, 0);
    else
      check(next_req && ch_enable, {tag, " R9 next item requested"}, next_req, 1);
  endtask

  initial begin
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; item_load = 1'b0; item_count = '0; item_periph_fc = 1'b0;
    item_m2m = 1'b0; item_chain_end = 1'b1; burst_sel = '0;
    req_burst = 1'b0; req_single = 1'b0; req_last_burst = 1'b0; req_last_single = 1'b0;
    cmd_ready = 1'b1; beat_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({ch_enable, cmd_valid, req_clr, tc_pulse, next_req} == 5'b0,
          "R10 reset outputs", {ch_enable, cmd_valid, req_clr, tc_pulse, next_req}, 0);

    for (int i = 0; i < NV; i++) run_item(VECS[i], 1'b1, $sformatf("vec%0d", i));

    // R9 chained items: first item leaves the channel waiting, second closes it
    run_item('{1'b0, 1'b0, 2'd0, 2'd1, 12'd4, 4'd0, 8'd4, 4'd1, 5'd4}, 1'b0, "chain_a");
    run_item('{1'b0, 1'b0, 2'd1, 2'd2, 12'd2, 4'd0, 8'd2, 4'd2, 5'd1}, 1'b1, "chain_b");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule